// File: doc/BRIEF.md
# APB Manager Transfer Sequencer

This block drives one APB segment from the manager side. Read and write requests enter through a valid/ready request port and wait in a small in-order queue. The sequencer takes them one at a time and walks each through the three bus phases. In the rest phase both select and enable are low. In the setup phase the select is high and the enable is low. In the access phase both are high. The block waits in the access phase for the subordinate's ready. It then returns a one-cycle response beat that carries the read data and the error flag.

The select line is the only thing that starts a transfer. The block raises it only when a request is queued. Address, direction and write data are valid in that same cycle. While the bus rests, those lines keep whatever the last transfer left on them. When a transfer completes and another request is already queued, the next setup phase follows at once, with no rest cycle between. When the queue is empty, the bus goes back to rest.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low exactly when the queue holds `QUEUE_DEPTH` entries. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the consumer must take it in that cycle.

Top module: `apb_txn_sequencer`

## Requirements
- R1: After a clock edge with `rst_n` low, `psel`, `penable` and `rsp_valid` are low, `req_ready` is high and the queue is empty.
- R2: While no request is queued and no transfer is in flight, `psel` and `penable` both stay low, whatever `pready`, `prdata` and `pslverr` do.
- R3: A request taken at edge k into an empty, resting block raises `psel` with `penable` low after edge k+1. `paddr`, `pwrite` and `pwdata` carry that request's fields in the same cycle (`pwrite` high means write).
- R4: Every setup cycle (`psel` high, `penable` low) is followed by an access cycle: `psel` high, `penable` high.
- R5: While `psel` and `penable` are high and `pready` is low, the next cycle keeps the access phase, and `paddr`, `pwrite` and `pwdata` are unchanged.
- R6: An access cycle with `pready` high and no queued request is followed by a cycle with `psel` and `penable` low.
- R7: An access cycle with `pready` high while a request is queued is followed directly by a setup cycle of the next request (`psel` high, `penable` low).
- R8: For a read, the cycle after its completing access cycle shows `rsp_valid` high, `rsp_write` low, `rsp_rdata` equal to the `prdata` sampled at completion and `rsp_err` equal to the sampled `pslverr`.
- R9: For a write, the response beat has `rsp_write` high, `rsp_err` equal to the sampled `pslverr` and `rsp_rdata` zero.
- R10: The queue holds up to `QUEUE_DEPTH` (default 4) requests and issues them in arrival order. `req_ready` is low exactly when it is full.
- R11: A reset during a transfer drops the transfer and all queued requests. No response is produced for any of them.
- R12: `rsp_valid` pulses exactly once per completed transfer and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the request side |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data (ignored for reads) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rsp_err | output | 1 | Subordinate error flag |
| psel | output | 1 | Subordinate select |
| penable | output | 1 | Access-phase enable |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pready | input | 1 | Subordinate ready |
| prdata | input | DATA_W | Subordinate read data |
| pslverr | input | 1 | Subordinate error |

## Verification
A corrupt phase register shows up on `psel` or `penable` within one cycle. Examples are a setup phase that skips access, or an access phase that ignores `pready`. A queue pointer or count fault shows up as a wrong address or data in the next setup cycle, or as `req_ready` dropping at the wrong fill level. A fault in response capture shows up in the cycle after completion, as a missing, extra or wrong response beat. The bench keeps a reference model in lockstep and compares every output on every cycle, so each of these faults is reported within one or two cycles of its cause.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;
  typedef enum logic [1:0] {
    PH_REST   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;
endpackage

// File: rtl/seq_req_fifo.sv
module seq_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] count;

  // pointer wrap: free wrap for power-of-two depths, compare otherwise
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
    end else begin : g_mod
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = slots[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import apb_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          have_req,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          pready,
  output logic          take,
  output logic          done,
  output logic          done_write,
  output logic          psel,
  output logic          penable,
  output logic [AW-1:0] paddr,
  output logic          pwrite,
  output logic [DW-1:0] pwdata
);
  phase_e phase, phase_nxt;

  always_comb begin
    done      = (phase == PH_ACCESS) && pready;
    take      = 1'b0;
    phase_nxt = phase;
    unique case (phase)
      PH_REST: begin
        if (have_req) begin
          take      = 1'b1;
          phase_nxt = PH_SETUP;
        end
      end
      PH_SETUP: phase_nxt = PH_ACCESS;
      PH_ACCESS: begin
        if (pready) begin
          take      = have_req;
          phase_nxt = have_req ? PH_SETUP : PH_REST;
        end
      end
      default: phase_nxt = PH_REST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_REST;
      paddr  <= '0;
      pwrite <= 1'b0;
      pwdata <= '0;
    end else begin
      phase <= phase_nxt;
      // bus fields only move when a new request is loaded; stale at rest
      if (take) begin
        paddr  <= req_addr;
        pwrite <= req_write;
        pwdata <= req_wdata;
      end
    end
  end

  assign psel       = (phase != PH_REST);
  assign penable    = (phase == PH_ACCESS);
  assign done_write = pwrite;
endmodule

// File: rtl/seq_rsp_reg.sv
module seq_rsp_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          done_write,
  input  logic [DW-1:0] prdata,
  input  logic          pslverr,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_write <= done_write;
        rsp_rdata <= done_write ? '0 : prdata;
        rsp_err   <= pslverr;
      end
    end
  end
endmodule

// File: rtl/apb_txn_sequencer.sv
module apb_txn_sequencer #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              psel,
  output logic              penable,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic              pready,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr
);
  localparam int REQ_W = 1 + ADDR_W + DATA_W;

  logic [REQ_W-1:0]  q_in, q_out;
  logic              q_empty, q_full, q_push, q_pop;
  logic              done, done_write;
  logic              head_write;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_wdata;

  assign q_in      = {req_write, req_addr, req_wdata};
  assign req_ready = !q_full;
  assign q_push    = req_valid && !q_full;
  assign {head_write, head_addr, head_wdata} = q_out;

  seq_req_fifo #(.W(REQ_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (q_in),
    .pop   (q_pop),
    .dout  (q_out),
    .empty (q_empty),
    .full  (q_full)
  );

  seq_phase_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .have_req   (!q_empty),
    .req_write  (head_write),
    .req_addr   (head_addr),
    .req_wdata  (head_wdata),
    .pready     (pready),
    .take       (q_pop),
    .done       (done),
    .done_write (done_write),
    .psel       (psel),
    .penable    (penable),
    .paddr      (paddr),
    .pwrite     (pwrite),
    .pwdata     (pwdata)
  );

  seq_rsp_reg #(.DW(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .done_write (done_write),
    .prdata     (prdata),
    .pslverr    (pslverr),
    .rsp_valid  (rsp_valid),
    .rsp_write  (rsp_write),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
  );
endmodule

// File: rtl/apb_seq_checks.sv
module apb_seq_checks #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic [AW-1:0] paddr,
  input logic          pwrite,
  input logic [DW-1:0] pwdata,
  input logic          pready,
  input logic          rsp_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!psel && !penable && !rsp_valid));

  assert_rest_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> !penable);

  assert_setup_then_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable));

  assert_access_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  assert_done_leaves_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |=> !penable);

  assert_rsp_follows_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) |=> rsp_valid);

  assert_rsp_only_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(psel && penable && pready));
endmodule

bind apb_txn_sequencer apb_seq_checks #(.AW(ADDR_W), .DW(DATA_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .paddr     (paddr),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pready    (pready),
  .rsp_valid (rsp_valid)
);

// File: tb/apb_txn_sequencer_test.sv
`timescale 1ns/100ps
module apb_txn_sequencer_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_write, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic pready = 1'b0, pslverr = 1'b0;
  logic [DW-1:0] prdata = '0;

  always #2.5 clk = ~clk;

  apb_txn_sequencer #(.ADDR_W(AW), .DATA_W(DW), .QUEUE_DEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
    .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit            mq_w[$];
  logic [AW-1:0] mq_a[$];
  logic [DW-1:0] mq_d[$];
  int            m_phase = 0;          // 0 rest, 1 setup, 2 access
  logic [AW-1:0] m_addr = '0;
  logic          m_write = 1'b0;
  logic [DW-1:0] m_wdata = '0;
  bit            m_rv = 0, m_rw = 0, m_re = 0;
  logic [DW-1:0] m_rd = '0;
  bit            m_last_done = 0, m_last_chain = 0, started = 0;
  int            hit_chain = 0, hit_rest = 0, hit_full = 0, hit_wait = 0;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mq_w.delete(); mq_a.delete(); mq_d.delete();
      m_phase = 0; m_rv = 0; m_last_done = 0; m_last_chain = 0;
    end else begin
      bit have, acc, fin;
      have = (mq_a.size() != 0);
      acc  = req_valid && (mq_a.size() < QD);
      fin  = (m_phase == 2) && pready;
      if (m_phase == 2 && !pready) hit_wait++;
      m_rv = fin;
      if (fin) begin
        m_rw = m_write;
        m_re = pslverr;
        m_rd = m_write ? '0 : prdata;
      end
      m_last_done  = fin;
      m_last_chain = fin && have;
      if ((m_phase == 0 && have) || (fin && have)) begin
        m_phase = 1;
        m_write = mq_w.pop_front();
        m_addr  = mq_a.pop_front();
        m_wdata = mq_d.pop_front();
      end else if (m_phase == 1) m_phase = 2;
      else if (fin) m_phase = 0;
      if (acc) begin
        mq_w.push_back(req_write); mq_a.push_back(req_addr); mq_d.push_back(req_wdata);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (started && !finished) begin
      string ptag;
      ptag = m_last_chain ? "R7 psel" : (m_last_done ? "R6 psel" : (m_phase == 0 ? "R2 psel" : "R3 psel"));
      chk(psel === (m_phase != 0), ptag, 64'(psel), 64'(m_phase != 0));
      chk(penable === (m_phase == 2), (m_phase == 0) ? "R2 penable" : "R4 penable",
          64'(penable), 64'(m_phase == 2));
      if (m_phase != 0) begin
        chk(paddr === m_addr,   (m_phase == 2) ? "R5 paddr"  : "R3 paddr",  64'(paddr),  64'(m_addr));
        chk(pwrite === m_write, (m_phase == 2) ? "R5 pwrite" : "R3 pwrite", 64'(pwrite), 64'(m_write));
        chk(pwdata === m_wdata, (m_phase == 2) ? "R5 pwdata" : "R3 pwdata", 64'(pwdata), 64'(m_wdata));
      end
      chk(req_ready === (mq_a.size() < QD), "R10 req_ready", 64'(req_ready), 64'(mq_a.size() < QD));
      if (mq_a.size() == QD) hit_full++;
      if (m_last_chain) hit_chain++;
      if (m_last_done && !m_last_chain) hit_rest++;
      chk(rsp_valid === m_rv, "R12 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk(rsp_write === m_rw, "R9 rsp_write", 64'(rsp_write), 64'(m_rw));
        chk(rsp_err === m_re, m_rw ? "R9 rsp_err" : "R8 rsp_err", 64'(rsp_err), 64'(m_re));
        chk(rsp_rdata === m_rd, m_rw ? "R9 rsp_rdata" : "R8 rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      end
    end
  end

  // ---------------- subordinate stimulus ----------------
  logic [31:0] lf = 32'h1D2C_3B4A;
  int wait_mode = 0;
  always @(negedge clk) begin
    lf      = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    pready  = (wait_mode == 0) ? 1'b1 : (lf[3] & lf[7]);
    prdata  = lf ^ 32'hA5A5_0F0F;
    pslverr = lf[9] & lf[2];
  end

  task automatic send(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;              // garbage while not offered
  endtask

  task automatic drain();
    while (mq_a.size() != 0 || m_phase != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!psel && !penable && !rsp_valid && req_ready, "R1 reset state",
        {60'd0, psel, penable, rsp_valid, req_ready}, 64'h1);
    rst_n = 1'b1;
    // R2: long rest with subordinate noise
    wait_mode = 1;
    repeat (12) @(negedge clk);
    wait_mode = 0;
    // R3/R6/R9: single write, zero wait
    send(1'b1, 16'h0040, 32'hCAFE_0001);
    drain();
    // R8: single read, zero wait
    send(1'b0, 16'h0044, 32'h0);
    drain();
    // R7/R10: back-to-back burst that fills the queue
    for (int i = 0; i < 8; i++) send(i[0], 16'h0100 + 16'(i * 4), 32'h1000_0000 + i);
    drain();
    // R5: wait states, mixed traffic
    wait_mode = 1;
    for (int i = 0; i < 12; i++) send(i[1], 16'h0200 + 16'(i * 4), 32'h2000_0000 + i);
    drain();
    // R11: reset mid-transfer with a full queue
    for (int i = 0; i < 5; i++) send(1'b0, 16'h0300 + 16'(i), 32'h0);
    while (!(psel && penable)) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!psel && !rsp_valid && req_ready, "R11 reset drops work",
        {61'd0, psel, rsp_valid, req_ready}, 64'h1);
    wait_mode = 0;
    send(1'b1, 16'h0400, 32'h4444_0000);
    drain();
    chk(hit_chain > 0, "R7 chained setup seen", 64'(hit_chain), 64'd1);
    chk(hit_rest > 0, "R6 return to rest seen", 64'(hit_rest), 64'd1);
    chk(hit_full > 0, "R10 full queue seen", 64'(hit_full), 64'd1);
    chk(hit_wait > 0, "R5 wait state seen", 64'(hit_wait), 64'd1);
    summary();
  end
endmodule